// File: doc/BRIEF.md
# Keyboard scan-code port with acknowledge

This block sits between a keyboard event source and a processor's byte-wide I/O space. The source offers a 7-bit key code together with a press/release flag on a valid/ready pair. The port captures one event at a time, holds it in a code register, drops ready so the source keeps any further event to itself, and raises an interrupt request line for as long as the event is waiting.

The processor sees a window of four byte registers starting at a parameterised base address (0x60 by default). Offset 0 returns the captured code with the release flag in its top bit. Offset 1 is an output register driven onto output pins. Its top bit serves as the acknowledge: software sets it and then clears it, and the clearing write frees the code register. Offset 2 returns an auxiliary input byte taken straight from pins. Offset 3 is a command byte that is stored and read back. Reads have no side effects.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset, key_ready_o is 1, irq_o is 0, and the code register, the output register and the command register all read 0. out_port_o is 0.
- R2: In a cycle with key_valid_i=1 and key_ready_o=1, the port captures the event. Afterwards a read at offset 0 returns bit 7 = key_break_i (0 for press, 1 for release) and bits 6:0 = key_code_i.
- R3: From the capturing edge onward, key_ready_o is 0 and irq_o is 1, and both stay that way until the acknowledge completes.
- R4: While a code is waiting, key_valid_i and new values on key_code_i and key_break_i have no effect. Offset 0 keeps the first event.
- R5: The acknowledge completes on a write to offset 1 with bit 7 = 0 while the stored bit 7 is 1. From the next cycle, key_ready_o is 1 and irq_o is 0. A source still holding valid is then captured on the following edge.
- R6: None of these frees a waiting code: writing bit 7 = 1, writing bit 7 = 0 while it is already 0, or rewriting bits 6:0 while bit 7 stays 1.
- R7: Bits 6:0 of offset 1 are plain storage. They read back, appear on out_port_o, and have no effect on key_ready_o or irq_o.
- R8: A read at offset 2 returns aux_in_i unchanged in the same cycle.
- R9: Offset 3 stores any written byte and reads it back.
- R10: Writes to offsets 0 and 2 are ignored. Addresses outside the four-byte window read as 0, and writes to them are ignored.
- R11: Reading offset 0 repeatedly neither clears irq_o nor changes the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_valid_i | input | 1 | Source has a key event |
| key_code_i | input | 7 | Key scan code |
| key_break_i | input | 1 | 1 = key released, 0 = key pressed |
| key_ready_o | output | 1 | Port can take an event |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for io_addr_i (combinational) |
| aux_in_i | input | 8 | Auxiliary input byte seen at offset 2 |
| out_port_o | output | 8 | Output register contents |
| irq_o | output | 1 | Interrupt request, high while a code waits |

## Verification
The hardest case to reach is a source that keeps presenting a second event through the whole wait window while software tries partial acknowledges. The stimulus holds key_valid_i high with a different code across writes that set bit 7, repeat it with changed low bits, or clear it when it is already clear. It checks on every cycle that ready stays low and offset 0 keeps the first event. Only then does it clear the set bit 7 and confirm that the held event is taken one cycle after ready returns.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  // offset within the four-byte window; order fixed by the address map
  typedef enum logic [1:0] {
    REG_CODE = 2'd0,
    REG_OUT  = 2'd1,
    REG_AUX  = 2'd2,
    REG_CMD  = 2'd3
  } kbd_reg_e;
endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output kbd_reg_e          reg_o
);
  assign hit_o = (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign reg_o = kbd_reg_e'(addr_i[1:0]);
endmodule

// File: rtl/kbd_code_latch.sv
module kbd_code_latch #(
  parameter int unsigned CODE_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic            brk_i,
  input  logic            ack_i,
  output logic            ready_o,
  output logic [CODE_W:0] code_o
);
  logic            full_q;
  logic [CODE_W:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      code_q <= '0;
    end else if (!full_q && valid_i) begin
      full_q <= 1'b1;
      code_q <= {brk_i, code_i};
    end else if (full_q && ack_i) begin
      full_q <= 1'b0;
    end
  end

  assign ready_o = ~full_q;
  assign code_o  = code_q;

  assert_capture_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (code_o == $past({brk_i, code_i})));
  assert_capture_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  assert_hold_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o) |=> $stable(code_o));
  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ready_o) |=> ready_o);
endmodule

// File: rtl/kbd_out_reg.sv
module kbd_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] out_o,
  output logic              ack_o
);
  localparam int unsigned ACK_BIT = DATA_W - 1;

  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (wr_i) out_q <= wdata_i;
  end

  // acknowledge completes on the write that takes the top bit from 1 to 0
  assign ack_o = wr_i & out_q[ACK_BIT] & ~wdata_i[ACK_BIT];
  assign out_o = out_q;

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !out_o[ACK_BIT]);
  assert_ack_only_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_o[ACK_BIT]) |-> $past(ack_o));
endmodule

// File: rtl/kbd_byte_reg.sv
module kbd_byte_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  assert_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [DATA_W-2:0] key_code_i,
  input  logic              key_break_i,
  output logic              key_ready_o,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic [DATA_W-1:0] aux_in_i,
  output logic [DATA_W-1:0] out_port_o,
  output logic              irq_o
);
  localparam int unsigned CODE_W = DATA_W - 1;

  logic              hit;
  kbd_reg_e          sel;
  logic              wr_out, wr_cmd, ack;
  logic [DATA_W-1:0] code_byte, cmd_byte;

  kbd_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(io_addr_i), .hit_o(hit), .reg_o(sel)
  );

  assign wr_out = io_wr_i & hit & (sel == REG_OUT);
  assign wr_cmd = io_wr_i & hit & (sel == REG_CMD);

  kbd_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_out), .wdata_i(io_wdata_i),
    .out_o(out_port_o), .ack_o(ack)
  );

  kbd_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(key_valid_i), .code_i(key_code_i),
    .brk_i(key_break_i), .ack_i(ack), .ready_o(key_ready_o), .code_o(code_byte)
  );

  kbd_byte_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_cmd), .wdata_i(io_wdata_i), .q_o(cmd_byte)
  );

  assign irq_o = ~key_ready_o;

  always_comb begin
    io_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        REG_CODE: io_rdata_o = code_byte;
        REG_OUT:  io_rdata_o = out_port_o;
        REG_AUX:  io_rdata_o = aux_in_i;
        REG_CMD:  io_rdata_o = cmd_byte;
        default:  io_rdata_o = '0;
      endcase
    end
  end

  assert_irq_until_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> irq_o);
  assert_irq_on_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> irq_o);
  assert_outside_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (io_rdata_o == '0));
endmodule

// File: tb/sim_kbd_scan_port.sv
`timescale 1ns/1ps
module sim_kbd_scan_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kv = 1'b0;
  logic [6:0]  kc = '0;
  logic        kb = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  aux = '0;
  logic        ready, irq;
  logic [7:0]  rd, outp;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // reference state
  bit       m_full = 0;
  bit [7:0] m_code = 0, m_out = 0, m_cmd = 0;

  always #2.5 clk = ~clk;

  kbd_scan_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(kv), .key_code_i(kc), .key_break_i(kb),
    .key_ready_o(ready), .io_addr_i(addr), .io_wr_i(wr), .io_wdata_i(wd),
    .io_rdata_o(rd), .aux_in_i(aux), .out_port_o(outp), .irq_o(irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] exp_rd(input bit [15:0] a, input bit [7:0] x);
    if (a[15:2] != 14'h0018) return 8'h00;
    case (a[1:0])
      2'd0: return m_code;
      2'd1: return m_out;
      2'd2: return x;
      default: return m_cmd;
    endcase
  endfunction

  task automatic step(input bit v, input bit [6:0] c, input bit b,
                      input bit [15:0] a, input bit w, input bit [7:0] d, input bit [7:0] x);
    bit ackev;
    @(negedge clk);
    kv = v; kc = c; kb = b; addr = a; wr = w; wd = d; aux = x;
    #1;
    chk("ready", ready, !m_full);
    chk("irq", irq, m_full);
    chk("out_port", outp, m_out);
    chk("rdata", rd, exp_rd(a, x));
    @(posedge clk);
    ackev = 0;
    if (w && a == 16'h0061) begin
      ackev = m_out[7] && !d[7];
      m_out = d;
    end
    if (w && a == 16'h0063) m_cmd = d;
    if (!m_full && v) begin
      m_full = 1; m_code = {b, c};
    end else if (m_full && ackev) m_full = 0;
  endtask

  task automatic rd_at(input bit [15:0] a);
    step(0, 0, 0, a, 0, 0, 8'h00);
  endtask

  task automatic wr_at(input bit [15:0] a, input bit [7:0] d);
    step(0, 0, 0, a, 1, d, 8'h00);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd_at(16'h0060); rd_at(16'h0061); rd_at(16'h0063);
    // R2 press capture, R3 flags
    cur_req = "R2";
    step(1, 7'h1c, 0, 16'h0060, 0, 0, 0);
    rd_at(16'h0060);
    cur_req = "R3";
    rd_at(16'h0060); rd_at(16'h0061);
    // R11 repeated reads
    cur_req = "R11";
    repeat (4) rd_at(16'h0060);
    // R4 held event ignored while full
    cur_req = "R4";
    repeat (3) step(1, 7'h2a, 1, 16'h0060, 0, 0, 0);
    // R6 partial acknowledges with source still holding valid
    cur_req = "R6";
    step(1, 7'h2a, 1, 16'h0061, 1, 8'h00, 0);
    step(1, 7'h2a, 1, 16'h0061, 1, 8'h80, 0);
    step(1, 7'h2a, 1, 16'h0061, 1, 8'h85, 0);
    step(1, 7'h2a, 1, 16'h0060, 0, 0, 0);
    // R5 clearing bit 7 releases; held release event captured next
    cur_req = "R5";
    step(1, 7'h2a, 1, 16'h0061, 1, 8'h05, 0);
    step(1, 7'h2a, 1, 16'h0060, 0, 0, 0);
    step(0, 0, 0, 16'h0060, 0, 0, 0);
    rd_at(16'h0060);
    wr_at(16'h0061, 8'h80); wr_at(16'h0061, 8'h00);
    rd_at(16'h0060); rd_at(16'h0060);
    // R7 low bits are storage only
    cur_req = "R7";
    wr_at(16'h0061, 8'h2a); rd_at(16'h0061);
    wr_at(16'h0061, 8'h55); rd_at(16'h0061);
    step(1, 7'h7f, 0, 16'h0061, 1, 8'h7f, 0);
    rd_at(16'h0060);
    wr_at(16'h0061, 8'h01); rd_at(16'h0061);
    wr_at(16'h0061, 8'h81); wr_at(16'h0061, 8'h01);
    rd_at(16'h0060);
    // R8 aux input passthrough
    cur_req = "R8";
    step(0, 0, 0, 16'h0062, 0, 0, 8'ha5);
    step(0, 0, 0, 16'h0062, 0, 0, 8'h3c);
    // R9 command byte
    cur_req = "R9";
    wr_at(16'h0063, 8'hc3); rd_at(16'h0063);
    wr_at(16'h0063, 8'h00); rd_at(16'h0063);
    // R10 ignored writes and outside window
    cur_req = "R10";
    step(1, 7'h11, 0, 16'h0060, 0, 0, 0);
    wr_at(16'h0060, 8'hff); rd_at(16'h0060);
    wr_at(16'h0062, 8'hff); step(0, 0, 0, 16'h0062, 0, 0, 8'h12);
    wr_at(16'h0065, 8'h00); wr_at(16'h0067, 8'hee); rd_at(16'h0063);
    wr_at(16'h0161, 8'h80); wr_at(16'h0161, 8'h00);
    rd_at(16'h0064); rd_at(16'h005f); rd_at(16'h0061); rd_at(16'h0060);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule